// File: doc/BRIEF.md
# Bus Region Decoder with Boot Overlay

This block sits on a 16 MB processor bus with a 24-bit byte address and turns each bus cycle into at most one device select. The devices it can select are: chip RAM, slow expansion RAM, fast expansion RAM, two peripheral-interface chips (A and B), the custom register window, the autoconfig window and the boot ROM. Bus inputs are captured on the rising clock edge, and the selects are then decoded combinationally from that captured sample. As a result, every output reflects the cycle presented one edge earlier.

The block also owns the boot overlay, modelled as a two-state machine. Reset enters state `OVL_MIRROR`, in which reads at the bottom of memory (the chip RAM range) select the ROM, so that the processor can fetch its reset vectors. The single transition, "clear write", moves the machine to `OVL_OFF`. This transition fires on a write to port A (register index 0) of peripheral A with data bit 0 at zero. `OVL_OFF` has no exit other than reset.

For peripheral cycles, the block also reports a 4-bit register index and a slow-cycle flag. Those chips sit on a slower synchronous bus, and the flag tells the rest of the system which cycles need that handshake. Address ranges that are reserved, or that belong to expansion memory which is not fitted, raise `no_device` instead of a select.

Top module: `bus_region_decoder`

## Requirements
- R1: `dev_sel` is one-hot or zero. The bit positions are: 0 chip RAM, 1 slow RAM, 2 fast RAM, 3 peripheral A, 4 peripheral B, 5 custom registers, 6 autoconfig, 7 ROM. When the captured address strobe is low, `dev_sel`, `no_device`, `slow_cycle` and `reg_idx` are all zero.
- R2: Chip RAM is selected for $000000–$07FFFF. When `mode_1mb` is 1, it is selected for $000000–$0FFFFF instead. When `mode_1mb` is 0, $080000–$0FFFFF is unmapped.
- R3: Fast RAM is selected for $200000–$9FFFFF only while `fast_present` is 1. Slow RAM is selected for $C00000–$D7FFFF only while `slow_present` is 1.
- R4: Custom registers are selected for $DFF000–$DFF1FF. Autoconfig is selected for $E80000–$EFFFFF.
- R5: The ROM is selected for $FC0000–$FFFFFF.
- R6: Peripheral A is selected for $BFE000–$BFEFFF, but only with the low data strobe (`bus_lds`) active. Peripheral B is selected for $BFD000–$BFDFFF, but only with the upper strobe (`bus_uds`) active. During such a cycle, `reg_idx` equals address bits 11:8, and address bits 7:0 have no effect on it.
- R7: `slow_cycle` is 1 exactly when a peripheral select is asserted.
- R8: When the strobe is active and no device matches (reserved space, an unfitted expansion range, or a peripheral accessed on the wrong lane), `no_device` is 1 and `dev_sel` is zero.
- R9: After reset the overlay is on. In that state, a read in the chip RAM range selects the ROM, while a write in that range selects chip RAM.
- R10: The overlay turns off only on a write (`bus_read`=0) with `bus_lds`=1, peripheral A selected, `reg_idx`=0 and `bus_d0`=0. The change takes effect from the next captured cycle. Any other peripheral access leaves the overlay on.
- R11: Once the overlay is off, reads in the chip RAM range select chip RAM, and later writes do not turn the overlay back on. Only a reset does that.
- R12: The outputs follow the bus inputs that were captured on the previous rising edge. Reset clears the captured sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 24 | Byte address |
| bus_as | input | 1 | Address strobe, active high |
| bus_read | input | 1 | 1 for a read, 0 for a write |
| bus_uds | input | 1 | Upper (even) byte lane strobe |
| bus_lds | input | 1 | Lower (odd) byte lane strobe |
| bus_d0 | input | 1 | Write data bit 0 on the low lane |
| mode_1mb | input | 1 | Chip RAM spans 1 MB when 1 |
| fast_present | input | 1 | Fast expansion RAM fitted |
| slow_present | input | 1 | Slow expansion RAM fitted |
| dev_sel | output | 8 | One-hot device select |
| no_device | output | 1 | Strobe active but nothing mapped |
| reg_idx | output | 4 | Peripheral register index |
| slow_cycle | output | 1 | Cycle targets a peripheral chip |

## Verification
The bench probes both edges of every window, for example $07FFFE against $080000 and $D7FFFE against $D80000. A decoder with an off-by-one limit, or one that ignores the 1 MB mode or the presence flags, would either select RAM in a hole or leave a fitted range silent. Writes that come close to clearing the overlay without meeting every condition (data bit 0 at 1, index 1, a read) must leave reads at address zero going to the ROM. A decoder that clears the overlay too eagerly would hand the vector fetch to garbage RAM. After the real clearing write, the bench checks three things: that address zero is chip RAM on the very next cycle, that a later write with bit 0 set does not revive the overlay, and that a reset brings it back. Peripheral probes on the wrong lane, and with noise in address bits 7:0, catch lane-blind decoding and an index taken from the wrong bits.

// File: rtl/bdec_pkg.sv
package bdec_pkg;

    localparam int ADDR_W  = 24;
    localparam int IDX_W   = 4;
    localparam int NUM_DEV = 8;
    localparam int DEV_W   = $clog2(NUM_DEV);

    localparam int DEV_CHIP = 0;
    localparam int DEV_SLOW = 1;
    localparam int DEV_FAST = 2;
    localparam int DEV_PIA  = 3;
    localparam int DEV_PIB  = 4;
    localparam int DEV_CUST = 5;
    localparam int DEV_ACFG = 6;
    localparam int DEV_ROM  = 7;

    localparam logic [ADDR_W-1:0] CHIP_TOP_HALF = 24'h07FFFF;
    localparam logic [ADDR_W-1:0] CHIP_TOP_FULL = 24'h0FFFFF;
    localparam logic [ADDR_W-1:0] FAST_LO       = 24'h200000;
    localparam logic [ADDR_W-1:0] FAST_HI       = 24'h9FFFFF;
    localparam logic [ADDR_W-1:0] SLOW_LO       = 24'hC00000;
    localparam logic [ADDR_W-1:0] SLOW_HI       = 24'hD7FFFF;

    // Fixed windows: peripheral A, peripheral B, custom, autoconfig, ROM
    localparam int NUM_WIN = 5;
    localparam logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_LO = {
        24'hFC0000, 24'hE80000, 24'hDFF000, 24'hBFD000, 24'hBFE000};
    localparam logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_HI = {
        24'hFFFFFF, 24'hEFFFFF, 24'hDFF1FF, 24'hBFDFFF, 24'hBFEFFF};
    localparam logic [NUM_WIN-1:0][DEV_W-1:0] WIN_DEV = {
        3'(DEV_ROM), 3'(DEV_ACFG), 3'(DEV_CUST), 3'(DEV_PIB), 3'(DEV_PIA)};

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              as;
        logic              rd;
        logic              uds;
        logic              lds;
        logic              d0;
    } bus_sample_t;

    typedef enum logic [0:0] {
        OVL_MIRROR = 1'b0,
        OVL_OFF    = 1'b1
    } ovl_state_t;

endpackage

// File: rtl/bdec_bus_reg.sv
module bdec_bus_reg
    import bdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  bus_sample_t smp_d,
    output bus_sample_t smp_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

endmodule

// File: rtl/bdec_region_map.sv
module bdec_region_map
    import bdec_pkg::*;
(
    input  bus_sample_t        smp,
    input  logic               mode_1mb,
    input  logic               fast_present,
    input  logic               slow_present,
    input  logic               overlay_on,
    output logic [NUM_DEV-1:0] sel,
    output logic               no_device,
    output logic [IDX_W-1:0]   reg_idx,
    output logic               slow_cycle
);

    logic [NUM_WIN-1:0] win_hit;
    logic               chip_hit;
    logic               fast_hit;
    logic               slow_hit;
    logic [NUM_DEV-1:0] raw;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign win_hit[w] = (smp.addr >= WIN_LO[w]) && (smp.addr <= WIN_HI[w]);
    end

    always_comb begin
        chip_hit = mode_1mb ? (smp.addr <= CHIP_TOP_FULL)
                            : (smp.addr <= CHIP_TOP_HALF);
        fast_hit = fast_present && (smp.addr >= FAST_LO) && (smp.addr <= FAST_HI);
        slow_hit = slow_present && (smp.addr >= SLOW_LO) && (smp.addr <= SLOW_HI);

        raw = '0;
        if (chip_hit) begin
            if (overlay_on && smp.rd) begin
                raw[DEV_ROM] = 1'b1;
            end else begin
                raw[DEV_CHIP] = 1'b1;
            end
        end
        raw[DEV_FAST] = fast_hit;
        raw[DEV_SLOW] = slow_hit;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (win_hit[w]) begin
                raw[WIN_DEV[w]] = 1'b1;
            end
        end
        // each peripheral answers only on its own byte lane
        raw[DEV_PIA] = raw[DEV_PIA] && smp.lds;
        raw[DEV_PIB] = raw[DEV_PIB] && smp.uds;

        sel        = smp.as ? raw : '0;
        no_device  = smp.as && (raw == '0);
        slow_cycle = sel[DEV_PIA] || sel[DEV_PIB];
        reg_idx    = slow_cycle ? smp.addr[11:8] : '0;
    end

endmodule

// File: rtl/bdec_overlay_fsm.sv
module bdec_overlay_fsm
    import bdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_req,
    output logic overlay_on
);

    ovl_state_t state_q;
    ovl_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OVL_MIRROR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        overlay_on = 1'b0;
        unique case (state_q)
            OVL_MIRROR: begin
                overlay_on = 1'b1;
                if (clear_req) begin
                    state_d = OVL_OFF;
                end
            end
            OVL_OFF: begin
                overlay_on = 1'b0;
            end
            default: begin
                state_d    = OVL_MIRROR;
                overlay_on = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bus_region_decoder.sv
module bus_region_decoder
    import bdec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_as,
    input  logic               bus_read,
    input  logic               bus_uds,
    input  logic               bus_lds,
    input  logic               bus_d0,
    input  logic               mode_1mb,
    input  logic               fast_present,
    input  logic               slow_present,
    output logic [NUM_DEV-1:0] dev_sel,
    output logic               no_device,
    output logic [IDX_W-1:0]   reg_idx,
    output logic               slow_cycle
);

    bus_sample_t smp_d;
    bus_sample_t smp_q;
    logic        overlay_on;
    logic        clear_req;

    always_comb begin
        smp_d.addr = bus_addr;
        smp_d.as   = bus_as;
        smp_d.rd   = bus_read;
        smp_d.uds  = bus_uds;
        smp_d.lds  = bus_lds;
        smp_d.d0   = bus_d0;
    end

    bdec_bus_reg u_bus_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .smp_d (smp_d),
        .smp_q (smp_q)
    );

    bdec_region_map u_map (
        .smp          (smp_q),
        .mode_1mb     (mode_1mb),
        .fast_present (fast_present),
        .slow_present (slow_present),
        .overlay_on   (overlay_on),
        .sel          (dev_sel),
        .no_device    (no_device),
        .reg_idx      (reg_idx),
        .slow_cycle   (slow_cycle)
    );

    assign clear_req = !smp_q.rd && smp_q.lds && dev_sel[DEV_PIA]
                       && (reg_idx == '0) && !smp_q.d0;

    bdec_overlay_fsm u_ovl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_req  (clear_req),
        .overlay_on (overlay_on)
    );

endmodule

// File: rtl/bdec_checker.sv
module bdec_checker
    import bdec_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_as,
    input logic               bus_read,
    input logic               bus_lds,
    input logic               bus_d0,
    input logic [NUM_DEV-1:0] dev_sel,
    input logic               no_device,
    input logic [IDX_W-1:0]   reg_idx,
    input logic               slow_cycle
);

    logic seen_clear;
    logic port_clear;
    logic low_chip_rd;

    assign port_clear = bus_as && !bus_read && bus_lds && !bus_d0
                        && (bus_addr[23:8] == 16'hBFE0);
    assign low_chip_rd = bus_as && bus_read && (bus_addr <= CHIP_TOP_HALF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_clear <= 1'b0;
        end else if (port_clear) begin
            seen_clear <= 1'b1;
        end
    end

    // R1
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_sel));

    // R1
    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_as |=> (dev_sel == '0) && !no_device && !slow_cycle);

    // R5
    a_r5_rom: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as && (bus_addr[23:18] == 6'h3F) |=> dev_sel == NUM_DEV'(1 << DEV_ROM));

    // R6
    a_r6_pia_index: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as && bus_lds && (bus_addr[23:12] == 12'hBFE)
        |=> dev_sel[DEV_PIA] && (reg_idx == $past(bus_addr[11:8])));

    // R7
    a_r7_slow: assert property (@(posedge clk) disable iff (!rst_n)
        slow_cycle |-> (dev_sel[DEV_PIA] || dev_sel[DEV_PIB]));

    // R8
    a_r8_nodev: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |=> (no_device != (dev_sel != '0)));

    // R9
    a_r9_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_clear && low_chip_rd |=> dev_sel == NUM_DEV'(1 << DEV_ROM));

    // R11
    a_r11_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        seen_clear && low_chip_rd |=> dev_sel == NUM_DEV'(1 << DEV_CHIP));

endmodule

bind bus_region_decoder bdec_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_as     (bus_as),
    .bus_read   (bus_read),
    .bus_lds    (bus_lds),
    .bus_d0     (bus_d0),
    .dev_sel    (dev_sel),
    .no_device  (no_device),
    .reg_idx    (reg_idx),
    .slow_cycle (slow_cycle)
);

// File: tb/bus_region_decoder_bench.sv
module bus_region_decoder_bench;

    localparam int D_NONE = -1;
    localparam int D_CHIP = 0;
    localparam int D_SLOW = 1;
    localparam int D_FAST = 2;
    localparam int D_PIA  = 3;
    localparam int D_PIB  = 4;
    localparam int D_CUST = 5;
    localparam int D_ACFG = 6;
    localparam int D_ROM  = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_as = 1'b0;
    logic        bus_read = 1'b1;
    logic        bus_uds = 1'b0;
    logic        bus_lds = 1'b0;
    logic        bus_d0 = 1'b0;
    logic        mode_1mb = 1'b0;
    logic        fast_present = 1'b0;
    logic        slow_present = 1'b0;
    logic [7:0]  dev_sel;
    logic        no_device;
    logic [3:0]  reg_idx;
    logic        slow_cycle;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bus_region_decoder u_bus_region_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_as       (bus_as),
        .bus_read     (bus_read),
        .bus_uds      (bus_uds),
        .bus_lds      (bus_lds),
        .bus_d0       (bus_d0),
        .mode_1mb     (mode_1mb),
        .fast_present (fast_present),
        .slow_present (slow_present),
        .dev_sel      (dev_sel),
        .no_device    (no_device),
        .reg_idx      (reg_idx),
        .slow_cycle   (slow_cycle)
    );

    task automatic check(input string tag, input int dev, input logic [3:0] idx,
                         input logic strobe_on);
        logic [7:0] e_sel;
        logic       e_nd;
        logic       e_slow;
        e_sel  = (dev == D_NONE) ? 8'h00 : 8'(1 << dev);
        e_nd   = strobe_on && (dev == D_NONE);
        e_slow = (dev == D_PIA) || (dev == D_PIB);
        n_chk++;
        if (dev_sel !== e_sel || no_device !== e_nd || slow_cycle !== e_slow
            || reg_idx !== (e_slow ? idx : 4'h0)) begin
            n_bad++;
            $display("FAIL %s: sel=%b nd=%b slow=%b idx=%h expected sel=%b nd=%b slow=%b idx=%h",
                     tag, dev_sel, no_device, slow_cycle, reg_idx,
                     e_sel, e_nd, e_slow, e_slow ? idx : 4'h0);
        end
    endtask

    // drive one cycle at a falling edge, sample at the next falling edge
    task automatic probe(input string tag, input logic [23:0] a, input logic rd,
                         input logic uds, input logic lds, input logic d0,
                         input int dev, input logic [3:0] idx);
        @(negedge clk);
        bus_addr = a; bus_as = 1'b1; bus_read = rd;
        bus_uds = uds; bus_lds = lds; bus_d0 = d0;
        @(negedge clk);
        bus_as = 1'b0; bus_uds = 1'b0; bus_lds = 1'b0;
        check(tag, dev, idx, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_as = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R12 reset state", D_NONE, 4'h0, 1'b0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        bus_addr = 24'hFC0000; bus_as = 1'b0; bus_read = 1'b1; bus_lds = 1'b1;
        @(negedge clk);
        check("R1 strobe inactive", D_NONE, 4'h0, 1'b0);
        bus_lds = 1'b0;
    endtask

    task automatic t_overlay_on();
        probe("R9 read zero mirrors ROM", 24'h000000, 1, 1, 1, 0, D_ROM, 0);
        probe("R9 read top of chip mirrors ROM", 24'h07FFFE, 1, 1, 1, 0, D_ROM, 0);
        probe("R9 write goes to chip RAM", 24'h000100, 0, 1, 1, 0, D_CHIP, 0);
    endtask

    task automatic t_fixed_regions();
        probe("R2 512K hole", 24'h080000, 1, 1, 1, 0, D_NONE, 0);
        probe("R8 reserved 1M", 24'h100000, 1, 1, 1, 0, D_NONE, 0);
        probe("R3 fast absent", 24'h300000, 1, 1, 1, 0, D_NONE, 0);
        probe("R3 slow absent", 24'hC40000, 1, 1, 1, 0, D_NONE, 0);
        probe("R8 io space", 24'hA00000, 1, 1, 1, 0, D_NONE, 0);
        probe("R4 custom", 24'hDFF180, 1, 1, 1, 0, D_CUST, 0);
        probe("R4 custom end", 24'hDFF1FE, 0, 1, 1, 0, D_CUST, 0);
        probe("R8 past custom", 24'hDFF200, 1, 1, 1, 0, D_NONE, 0);
        probe("R4 autoconfig", 24'hE80000, 1, 1, 1, 0, D_ACFG, 0);
        probe("R8 reserved F0", 24'hF00000, 1, 1, 1, 0, D_NONE, 0);
        probe("R5 ROM base", 24'hFC0000, 1, 1, 1, 0, D_ROM, 0);
        probe("R5 ROM top", 24'hFFFFFE, 1, 1, 1, 0, D_ROM, 0);
    endtask

    task automatic t_present();
        fast_present = 1'b1;
        slow_present = 1'b1;
        probe("R3 fast base", 24'h200000, 1, 1, 1, 0, D_FAST, 0);
        probe("R3 fast top", 24'h9FFFFE, 1, 1, 1, 0, D_FAST, 0);
        probe("R3 slow base", 24'hC00000, 1, 1, 1, 0, D_SLOW, 0);
        probe("R3 slow top", 24'hD7FFFE, 1, 1, 1, 0, D_SLOW, 0);
        probe("R8 past slow", 24'hD80000, 1, 1, 1, 0, D_NONE, 0);
        fast_present = 1'b0;
        slow_present = 1'b0;
    endtask

    task automatic t_periph();
        probe("R6 R7 pia port", 24'hBFE001, 1, 0, 1, 0, D_PIA, 4'h0);
        probe("R6 pia idx7", 24'hBFE701, 1, 0, 1, 0, D_PIA, 4'h7);
        probe("R6 pia low bits ignored", 24'hBFEDFF, 1, 0, 1, 0, D_PIA, 4'hD);
        probe("R6 R7 pib idx2", 24'hBFD200, 1, 1, 0, 0, D_PIB, 4'h2);
        probe("R6 pib idxF", 24'hBFDF80, 0, 1, 0, 0, D_PIB, 4'hF);
        probe("R8 pia wrong lane", 24'hBFE001, 1, 1, 0, 0, D_NONE, 0);
        probe("R8 pib wrong lane", 24'hBFD000, 1, 0, 1, 0, D_NONE, 0);
    endtask

    task automatic t_near_clear();
        probe("R10 write d0=1", 24'hBFE001, 0, 0, 1, 1, D_PIA, 4'h0);
        probe("R10 still mirrored a", 24'h000000, 1, 1, 1, 0, D_ROM, 0);
        probe("R10 write idx1", 24'hBFE101, 0, 0, 1, 0, D_PIA, 4'h1);
        probe("R10 still mirrored b", 24'h000000, 1, 1, 1, 0, D_ROM, 0);
        probe("R10 read port", 24'hBFE001, 1, 0, 1, 0, D_PIA, 4'h0);
        probe("R10 still mirrored c", 24'h000000, 1, 1, 1, 0, D_ROM, 0);
    endtask

    task automatic t_mode_1mb();
        mode_1mb = 1'b1;
        probe("R2 R9 1M read mirrored", 24'h0C0000, 1, 1, 1, 0, D_ROM, 0);
        probe("R2 1M write chip", 24'h0FFFFE, 0, 1, 1, 0, D_CHIP, 0);
        probe("R2 1M limit", 24'h100000, 0, 1, 1, 0, D_NONE, 0);
        mode_1mb = 1'b0;
    endtask

    task automatic t_clear();
        probe("R10 clearing write", 24'hBFE001, 0, 0, 1, 0, D_PIA, 4'h0);
        probe("R11 zero is chip", 24'h000000, 1, 1, 1, 0, D_CHIP, 0);
        probe("R11 top is chip", 24'h07FFFE, 1, 1, 1, 0, D_CHIP, 0);
        probe("R11 write d0=1", 24'hBFE001, 0, 0, 1, 1, D_PIA, 4'h0);
        probe("R11 stays clear", 24'h000000, 1, 1, 1, 0, D_CHIP, 0);
    endtask

    task automatic t_reentry();
        do_reset();
        check("R12 reset again", D_NONE, 4'h0, 1'b0);
        probe("R11 reset restores mirror", 24'h000000, 1, 1, 1, 0, D_ROM, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_idle();
        t_overlay_on();
        t_fixed_regions();
        t_present();
        t_periph();
        t_near_clear();
        t_mode_1mb();
        t_clear();
        t_reentry();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            summary();
        end
    end

endmodule